// File: doc/BRIEF.md
# Frequency Select with Watchdog Fallback

This block picks the five-bit frequency code that a clock synthesizer turns into divider settings. The code comes from one of two places: a set of strap pins whose levels are captured while reset is held, or a code that software writes into a select register over the serial configuration bus. A control register can also ask the synthesizer to take its dividers from direct programming instead of the table code. That flag is passed straight out.

A programmable watchdog guards against an over-clocked system that has stopped responding. Software enables it and restarts it at regular intervals. If a programmed number of slow time-base ticks passes without a restart, the block does not reset anything. It raises a sticky alarm status bit and forces the active code to a safe code held in the control register. The forced code stays in place until software writes the select register again.

Top module: `clksel_guard`

## Requirements
- R1: After reset, `freq_code` equals the captured strap levels, `direct_div` is 0, `wd_alarm` is 0, the watchdog is disabled and the timeout count is 0x10.
- R2: `strap_pins` is captured on every clock edge while `rst` is high. Changes on the pins after reset has been released have no effect on `freq_code` or `strap_readback`.
- R3: `strap_readback` is the bitwise inverse of the captured strap levels.
- R4: A write to the select register (`sel_wr`) with bit 3 = 1 sets `freq_code` to {bit 2, bits 7:4}, with bit 2 as the most significant bit. With bit 3 = 0, `freq_code` follows the strap code. Bits 1:0 are ignored.
- R5: Control register fields are: bit 7 = direct divider programming (driven on `direct_div`), bit 6 = watchdog enable, bit 5 = alarm status, bits 4:0 = safe code.
- R6: When the watchdog is enabled and the tick that completes the programmed count arrives with no restart in the same cycle, `wd_alarm` is 1 and `freq_code` equals the safe code from the next clock edge on.
- R7: A `wd_restart` pulse reloads the counter from the count register, so ticks received before the restart do not count toward the timeout.
- R8: A count register value of 0 behaves as a count of 1.
- R9: While the watchdog is disabled, ticks never raise the alarm. The counter holds the reload value, so after enabling, a full count of ticks is needed.
- R10: The alarm stays set until a control write with bit 5 = 0. A control write with bit 5 = 1 never sets it. Clearing the alarm does not change `freq_code`.
- R11: A write to the select register releases the safe-code override, and `freq_code` then follows the normal source selection.
- R12: With the reset count of 0x10, the alarm rises on the 16th tick after a restart and not on the 15th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high. Strap pins are captured while it is high. |
| strap_pins | input | 5 | Strap pin levels |
| sel_wr | input | 1 | Select register write strobe |
| sel_data | input | 8 | Select register write data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write data |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_data | input | CNT_W | Count register write data (timeout in ticks) |
| wd_restart | input | 1 | Watchdog restart pulse |
| tick | input | 1 | Slow time-base tick, one cycle wide |
| freq_code | output | 5 | Active frequency code |
| direct_div | output | 1 | Direct divider programming select |
| wd_alarm | output | 1 | Watchdog alarm status |
| strap_readback | output | 5 | Inverted captured strap code |

## Verification
The bench targets the edges of the timeout count. It checks that 15 ticks after a restart leave the alarm low and that the 16th raises it. A counter that is off by one would fire a tick early or late. It checks that a restart in the middle of a count discards the earlier ticks, that a count of 0 still fires after one tick instead of wrapping to 256, and that a disabled watchdog followed by enable needs the full count. A design that kept the partial count would alarm early. It also checks that clearing the alarm leaves the safe code in force until the select register is written, that writing a 1 to the status bit sets nothing, and that strap pins toggled after reset change neither the code nor the inverted readback.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] fcode_t;

    // Control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic   direct_div;
        logic   wd_en;
        logic   wd_alarm;
        fcode_t safe_code;
    } ctl_reg_t;

    // Select register layout, bit 7 down to bit 0
    typedef struct packed {
        logic [3:0] code_lo;
        logic       sw_sel;
        logic       code_msb;
        logic [1:0] spare;
    } sel_reg_t;

    typedef enum logic [1:0] {
        SRC_STRAP = 2'd0,
        SRC_SW    = 2'd1,
        SRC_SAFE  = 2'd2
    } src_e;

    function automatic fcode_t sel_to_code(sel_reg_t r);
        return {r.code_msb, r.code_lo};
    endfunction

    function automatic src_e pick_src(logic override, logic sw_sel);
        if (override)
            return SRC_SAFE;
        else if (sw_sel)
            return SRC_SW;
        else
            return SRC_STRAP;
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int                 CNT_W   = 8,
    parameter logic [CNT_W-1:0]   CNT_RST = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  fcode_t           strap_pins,
    input  logic             sel_wr,
    input  logic [7:0]       sel_data,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             timeout,
    output fcode_t           strap_q,
    output logic             sw_sel_q,
    output fcode_t           sw_code_q,
    output ctl_reg_t         ctl_q,
    output logic [CNT_W-1:0] cnt_q
);

    sel_reg_t sel_d;
    ctl_reg_t ctl_d;
    logic     sel_spare_unused;

    assign sel_d            = sel_reg_t'(sel_data);
    assign ctl_d            = ctl_reg_t'(ctl_data);
    assign sel_spare_unused = ^sel_d.spare;

    // Strap capture: follows the pins only while reset is held
    always_ff @(posedge clk) begin
        if (rst)
            strap_q <= strap_pins;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_sel_q  <= 1'b0;
            sw_code_q <= '0;
        end else if (sel_wr) begin
            sw_sel_q  <= sel_d.sw_sel;
            sw_code_q <= sel_to_code(sel_d);
        end
    end

    // Control fields; the alarm is set by hardware only and cleared by software
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q.direct_div <= ctl_d.direct_div;
                ctl_q.wd_en      <= ctl_d.wd_en;
                ctl_q.safe_code  <= ctl_d.safe_code;
            end
            if (timeout)
                ctl_q.wd_alarm <= 1'b1;
            else if (ctl_wr && !ctl_d.wd_alarm)
                ctl_q.wd_alarm <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_RST;
        else if (cnt_wr)
            cnt_q <= cnt_data;
    end

endmodule

// File: rtl/clksel_wdt.sv
module clksel_wdt #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] CNT_RST = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] reload;
    logic             last_unit;

    // A zero limit still has to expire
    assign reload    = (limit == '0) ? ONE : limit;
    assign last_unit = (remain <= ONE);
    assign timeout   = enable && tick && !restart && last_unit;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= CNT_RST;
        else if (!enable || restart)
            remain <= reload;
        else if (tick)
            remain <= last_unit ? reload : remain - ONE;
    end

endmodule

// File: rtl/clksel_src.sv
module clksel_src
    import clksel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fcode_t strap_q,
    input  logic   sw_sel_q,
    input  fcode_t sw_code_q,
    input  fcode_t safe_code,
    input  logic   timeout,
    input  logic   sel_wr,
    output fcode_t freq_code
);

    logic override_q;
    src_e src;

    // The forced safe code holds until software reprograms the select register
    always_ff @(posedge clk) begin
        if (rst)
            override_q <= 1'b0;
        else if (timeout)
            override_q <= 1'b1;
        else if (sel_wr)
            override_q <= 1'b0;
    end

    always_comb begin
        src = pick_src(override_q, sw_sel_q);
        unique case (src)
            SRC_SAFE: freq_code = safe_code;
            SRC_SW:   freq_code = sw_code_q;
            default:  freq_code = strap_q;
        endcase
    end

endmodule

// File: rtl/clksel_guard.sv
module clksel_guard
    import clksel_pkg::*;
#(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] CNT_RST = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       strap_pins,
    input  logic             sel_wr,
    input  logic [7:0]       sel_data,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             wd_restart,
    input  logic             tick,
    output logic [4:0]       freq_code,
    output logic             direct_div,
    output logic             wd_alarm,
    output logic [4:0]       strap_readback
);

    fcode_t           strap_q;
    logic             sw_sel_q;
    fcode_t           sw_code_q;
    ctl_reg_t         ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wd_timeout;

    clksel_regs #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .strap_pins(strap_pins),
        .sel_wr    (sel_wr),
        .sel_data  (sel_data),
        .ctl_wr    (ctl_wr),
        .ctl_data  (ctl_data),
        .cnt_wr    (cnt_wr),
        .cnt_data  (cnt_data),
        .timeout   (wd_timeout),
        .strap_q   (strap_q),
        .sw_sel_q  (sw_sel_q),
        .sw_code_q (sw_code_q),
        .ctl_q     (ctl_q),
        .cnt_q     (cnt_q)
    );

    clksel_wdt #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_wdt (
        .clk    (clk),
        .rst    (rst),
        .enable (ctl_q.wd_en),
        .restart(wd_restart),
        .tick   (tick),
        .limit  (cnt_q),
        .timeout(wd_timeout)
    );

    clksel_src u_src (
        .clk      (clk),
        .rst      (rst),
        .strap_q  (strap_q),
        .sw_sel_q (sw_sel_q),
        .sw_code_q(sw_code_q),
        .safe_code(ctl_q.safe_code),
        .timeout  (wd_timeout),
        .sel_wr   (sel_wr),
        .freq_code(freq_code)
    );

    assign direct_div     = ctl_q.direct_div;
    assign wd_alarm       = ctl_q.wd_alarm;
    assign strap_readback = ~strap_q;

endmodule

// File: rtl/clksel_guard_chk.sv
module clksel_guard_chk
    import clksel_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_data,
    input logic [4:0] freq_code,
    input logic       wd_alarm,
    input logic [4:0] strap_readback,
    input logic       timeout,
    input ctl_reg_t   ctl
);

    // R6: an expiry raises the alarm at the next edge
    p_timeout_alarm_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> wd_alarm);

    // R6: an expiry forces the safe code present at expiry
    p_timeout_safe_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (freq_code == $past(ctl.safe_code)));

    // R9: a disabled watchdog never expires
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl.wd_en |-> !timeout);

    // R10: the alarm holds unless software clears it
    p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (wd_alarm && !(ctl_wr && !ctl_data[5])) |=> wd_alarm);

    // R10: only an expiry can raise the alarm
    p_alarm_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_alarm) |-> $past(timeout));

    // R2: the strap capture is frozen out of reset
    p_strap_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_readback));

endmodule

bind clksel_guard clksel_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_wr        (ctl_wr),
    .ctl_data      (ctl_data),
    .freq_code     (freq_code),
    .wd_alarm      (wd_alarm),
    .strap_readback(strap_readback),
    .timeout       (wd_timeout),
    .ctl           (ctl_q)
);

// File: tb/clksel_guard_tb.sv
`timescale 1ns/1ps
module clksel_guard_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap_pins = 5'b10110;
    logic       sel_wr = 1'b0;
    logic [7:0] sel_data = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_data = '0;
    logic       wd_restart = 1'b0;
    logic       tick = 1'b0;
    logic [4:0] freq_code;
    logic       direct_div;
    logic       wd_alarm;
    logic [4:0] strap_readback;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    localparam logic [4:0] STRAP = 5'b10110;
    localparam logic [4:0] RB    = 5'b01001;
    localparam logic [4:0] SAFE  = 5'b00111;

    always #2.5 clk = ~clk;

    clksel_guard u_dut (
        .clk(clk), .rst(rst), .strap_pins(strap_pins),
        .sel_wr(sel_wr), .sel_data(sel_data),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .cnt_wr(cnt_wr), .cnt_data(cnt_data),
        .wd_restart(wd_restart), .tick(tick),
        .freq_code(freq_code), .direct_div(direct_div),
        .wd_alarm(wd_alarm), .strap_readback(strap_readback)
    );

    typedef struct {
        string      tag;
        logic [4:0] f;
        logic       d;
        logic       a;
        logic [4:0] rb;
    } exp_t;

    exp_t sb[$];

    task automatic expect_state(string tag, logic [4:0] f, logic d, logic a);
        exp_t e;
        @(posedge clk); #1;
        e.tag = tag; e.f = f; e.d = d; e.a = a; e.rb = RB;
        sb.push_back(e);
    endtask

    task automatic pulse_sel(logic [7:0] v);
        @(posedge clk); #1; sel_wr = 1'b1; sel_data = v;
        @(posedge clk); #1; sel_wr = 1'b0;
    endtask

    task automatic pulse_ctl(logic [7:0] v);
        @(posedge clk); #1; ctl_wr = 1'b1; ctl_data = v;
        @(posedge clk); #1; ctl_wr = 1'b0;
    endtask

    task automatic pulse_cnt(logic [7:0] v);
        @(posedge clk); #1; cnt_wr = 1'b1; cnt_data = v;
        @(posedge clk); #1; cnt_wr = 1'b0;
    endtask

    task automatic restart();
        @(posedge clk); #1; wd_restart = 1'b1;
        @(posedge clk); #1; wd_restart = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    // Monitor: compares each expected item against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (freq_code !== e.f || direct_div !== e.d ||
                    wd_alarm !== e.a || strap_readback !== e.rb) begin
                    errors++;
                    $display("FAIL %s: got code=%b dd=%b alarm=%b rb=%b, expected code=%b dd=%b alarm=%b rb=%b",
                             e.tag, freq_code, direct_div, wd_alarm, strap_readback,
                             e.f, e.d, e.a, e.rb);
                end
            end
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_state("R1 reset state, R3 inverted readback", STRAP, 1'b0, 1'b0);

        strap_pins = 5'b00011;
        repeat (2) @(posedge clk);
        expect_state("R2 pins ignored after reset", STRAP, 1'b0, 1'b0);

        pulse_sel(8'b0101_1111);
        expect_state("R4 software code {b2,b7:4}", 5'b10101, 1'b0, 1'b0);
        pulse_sel(8'b1010_0100);
        expect_state("R4 select bit 0 gives strap", STRAP, 1'b0, 1'b0);

        pulse_ctl(8'h80);
        expect_state("R5 direct divider flag set", STRAP, 1'b1, 1'b0);
        pulse_ctl(8'h00);
        expect_state("R5 direct divider flag clear", STRAP, 1'b0, 1'b0);

        ticks(40);
        expect_state("R9 disabled watchdog stays quiet", STRAP, 1'b0, 1'b0);

        pulse_ctl(8'h47);
        restart();
        ticks(15);
        expect_state("R12 no alarm after 15 ticks", STRAP, 1'b0, 1'b0);
        ticks(1);
        expect_state("R6 R12 alarm and safe code on 16th tick", SAFE, 1'b0, 1'b1);

        pulse_ctl(8'h47);
        expect_state("R10 clear alarm keeps safe code", SAFE, 1'b0, 1'b0);
        pulse_ctl(8'h67);
        expect_state("R10 writing status 1 does not set alarm", SAFE, 1'b0, 1'b0);

        pulse_sel(8'b0011_1000);
        expect_state("R11 select write releases override", 5'b00011, 1'b0, 1'b0);

        pulse_cnt(8'd4);
        restart();
        ticks(3);
        restart();
        ticks(3);
        expect_state("R7 restart discards earlier ticks", 5'b00011, 1'b0, 1'b0);
        ticks(1);
        expect_state("R7 expiry after reloaded count", SAFE, 1'b0, 1'b1);

        pulse_ctl(8'h47);
        pulse_sel(8'b0011_1000);
        pulse_cnt(8'd0);
        restart();
        expect_state("R8 zero count before tick", 5'b00011, 1'b0, 1'b0);
        ticks(1);
        expect_state("R8 zero count expires after one tick", SAFE, 1'b0, 1'b1);

        pulse_ctl(8'h07);
        pulse_cnt(8'd3);
        ticks(10);
        expect_state("R9 disabled, alarm cleared, no expiry", SAFE, 1'b0, 1'b0);
        pulse_ctl(8'h47);
        ticks(2);
        expect_state("R9 enable starts full count", SAFE, 1'b0, 1'b0);
        ticks(1);
        expect_state("R9 expiry after full count", SAFE, 1'b0, 1'b1);

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule